// File: doc/BRIEF.md
# Sized Register Port Validator

This block stands between a big-endian CPU request port and a 4 KiB register page. Every request carries a byte offset, a size code (one, two or four bytes) and a direction. The block decides, before anything is touched, whether that combination of offset and size is legal. Legal accesses to the control registers go to the register file as a one-cycle strobe. Illegal accesses are answered with an error and have no effect anywhere.

A four-byte data window gives the CPU a path into PCI I/O space. Whether an access to this window is legal depends on the byte lane it starts at. A legal window access does not go to the lane's own offset. It becomes a downstream I/O request to the address supplied on `io_window_base`. That request keeps the CPU's size and puts the data in big-endian byte order. The request is held until the I/O side acknowledges it, and the I/O side's error flag comes back to the CPU as the response error.

Only one access is in flight at a time. `req_ready` is low from the cycle after acceptance until the response has been given.

Top module: `sized_port_validator`

## Requirements
- R1: A request at one of the control offsets 0x004, 0x00C, 0x010, 0x014, 0x018, 0x01C, 0x024, 0x028, 0x038 or 0x060, with size code 0 (byte), 1 (halfword) or 2 (word), is accepted. In the cycle after acceptance, `reg_stb` is high for one cycle with the request's offset, size, direction and data. In that same cycle `rsp_valid` is high, `rsp_err` is low and `rsp_rdata` equals `reg_rdata`.
- R2: A request at any offset that is neither a control offset nor inside the window 0x06C..0x06F is rejected. In the cycle after acceptance, `rsp_valid` and `rsp_err` are high and `rsp_rdata` is zero. Neither `reg_stb` nor `io_req_valid` is raised.
- R3: Window lane 0 (offset 0x06C) accepts size codes 0, 1 and 2.
- R4: Window lane 2 (offset 0x06E) accepts size codes 0 and 1, and rejects code 2 as in R2.
- R5: Window lanes 1 and 3 (offsets 0x06D and 0x06F) accept only size code 0, and reject codes 1 and 2 as in R2.
- R6: Size code 3 is rejected as in R2 at every offset.
- R7: An accepted window access raises `io_req_valid` in the cycle after acceptance. `io_req_addr` equals `io_window_base`, and `io_req_size` and `io_req_write` equal the request's size code and direction. All of these hold steady until the cycle in which `io_ack` is high.
- R8: Window write data is sent in big-endian order within the access size. For a request value with bytes b3 b2 b1 b0 (b0 least significant), `io_req_wdata` is {b0,b1,b2,b3} for a word, {0,0,b0,b1} for a halfword and {0,0,0,b0} for a byte.
- R9: When `io_ack` is high, the response appears in the next cycle. `rsp_err` equals `io_err`. For a read, `rsp_rdata` is `io_rdata` reordered by the same rule as R8, with the bytes outside the size forced to zero. For a write, `rsp_rdata` is zero.
- R10: `rsp_valid` is a single-cycle pulse. `req_ready` is low while a response or an I/O request is outstanding, and high again in the cycle after the response.
- R11: After reset, `req_ready` is high and `rsp_valid`, `reg_stb` and `io_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_off | input | 12 | Byte offset in the register page |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word, 3 illegal |
| req_write | input | 1 | 1 for a write |
| req_wdata | input | 32 | Write value, right-justified |
| io_window_base | input | 16 | I/O address targeted by window accesses |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Read value, right-justified |
| reg_stb | output | 1 | Register file access strobe |
| reg_off | output | 12 | Register offset |
| reg_size | output | 2 | Register access size code |
| reg_write | output | 1 | Register access is a write |
| reg_wdata | output | 32 | Register write value |
| reg_rdata | input | 32 | Register file read value while `reg_stb` is high |
| io_req_valid | output | 1 | Downstream I/O request present |
| io_req_addr | output | 16 | I/O address |
| io_req_size | output | 2 | I/O size code |
| io_req_write | output | 1 | I/O access is a write |
| io_req_wdata | output | 32 | I/O write data in big-endian order |
| io_ack | input | 1 | I/O side completes the request |
| io_rdata | input | 32 | I/O read data, valid with `io_ack` |
| io_err | input | 1 | I/O error, valid with `io_ack` |

## Verification
A request is sampled on the clock edge where `req_valid` and `req_ready` are both high. Control and rejected accesses answer one cycle later. A window access raises its I/O request one cycle later, and its response follows one cycle after the edge that sees `io_ack`. The bench drives inputs and samples outputs on falling edges. It therefore reads each result in exactly the cycle it is due. It then checks one cycle further that the pulse has ended and that `req_ready` is back. For window accesses, the bench holds `io_ack` low for one extra cycle to confirm that the I/O request stays steady.

// File: rtl/spv_pkg.sv
package spv_pkg;

    localparam int OFF_W  = 12;
    localparam int DATA_W = 32;
    localparam int NBYTES = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        CLS_REJECT = 2'd0,
        CLS_CTRL   = 2'd1,
        CLS_IOWIN  = 2'd2
    } acc_class_e;

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        acc_size_e         size;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

    localparam int NUM_CTRL = 10;
    localparam logic [NUM_CTRL*OFF_W-1:0] CTRL_OFFS = {
        12'h004, 12'h00C, 12'h010, 12'h014, 12'h018,
        12'h01C, 12'h024, 12'h028, 12'h038, 12'h060
    };

    localparam logic [OFF_W-1:0] WIN_BASE = 12'h06C;

    function automatic int size_bytes(acc_size_e s);
        case (s)
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            SZ_WORD: return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/spv_classifier.sv
module spv_classifier
    import spv_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    output acc_class_e       cls
);
    logic [NUM_CTRL-1:0] ctrl_hit;

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        assign ctrl_hit[g] = (off == CTRL_OFFS[g*OFF_W +: OFF_W]);
    end

    logic       in_window;
    logic [1:0] lane;
    logic       lane_ok;

    assign in_window = (off[OFF_W-1:2] == WIN_BASE[OFF_W-1:2]);
    assign lane      = off[1:0];

    always_comb begin
        case (lane)
            2'd0:    lane_ok = (size != SZ_BAD);
            2'd2:    lane_ok = (size == SZ_BYTE) || (size == SZ_HALF);
            default: lane_ok = (size == SZ_BYTE);
        endcase
    end

    always_comb begin
        cls = CLS_REJECT;
        if (in_window && lane_ok)
            cls = CLS_IOWIN;
        else if ((|ctrl_hit) && size != SZ_BAD)
            cls = CLS_CTRL;
    end

endmodule

// File: rtl/spv_byte_order.sv
module spv_byte_order
    import spv_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] dout
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        always_comb begin
            int n;
            n = size_bytes(size);
            if (i < n)
                dout[i*8 +: 8] = din[(n-1-i)*8 +: 8];
            else
                dout[i*8 +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/sized_port_validator.sv
module sized_port_validator
    import spv_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [11:0]       req_off,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic [IO_AW-1:0]  io_window_base,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic              reg_stb,
    output logic [11:0]       reg_off,
    output logic [1:0]        reg_size,
    output logic              reg_write,
    output logic [31:0]       reg_wdata,
    input  logic [31:0]       reg_rdata,
    output logic              io_req_valid,
    output logic [IO_AW-1:0]  io_req_addr,
    output logic [1:0]        io_req_size,
    output logic              io_req_write,
    output logic [31:0]       io_req_wdata,
    input  logic              io_ack,
    input  logic [31:0]       io_rdata,
    input  logic              io_err
);
    typedef enum logic [1:0] {ST_IDLE, ST_IO, ST_RSP} state_e;

    state_e     state_q;
    acc_req_t   req_in;
    acc_class_e cls;
    logic [DATA_W-1:0] wdata_be, rdata_be;

    logic              rsp_valid_q, rsp_err_q, from_reg_q, reg_stb_q;
    logic [DATA_W-1:0] rdata_q;
    acc_req_t          reg_q;
    logic              io_valid_q, io_write_q;
    logic [IO_AW-1:0]  io_addr_q;
    acc_size_e         io_size_q;
    logic [DATA_W-1:0] io_wdata_q;

    assign req_in.off   = req_off;
    assign req_in.size  = acc_size_e'(req_size);
    assign req_in.write = req_write;
    assign req_in.wdata = req_wdata;

    spv_classifier u_cls (
        .off  (req_in.off),
        .size (req_in.size),
        .cls  (cls)
    );

    spv_byte_order u_wr_order (
        .din  (req_in.wdata),
        .size (req_in.size),
        .dout (wdata_be)
    );

    spv_byte_order u_rd_order (
        .din  (io_rdata),
        .size (io_size_q),
        .dout (rdata_be)
    );

    assign req_ready = (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            from_reg_q  <= 1'b0;
            rdata_q     <= '0;
            reg_stb_q   <= 1'b0;
            reg_q       <= '0;
            io_valid_q  <= 1'b0;
            io_write_q  <= 1'b0;
            io_addr_q   <= '0;
            io_size_q   <= SZ_BYTE;
            io_wdata_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    rsp_valid_q <= 1'b0;
                    reg_stb_q   <= 1'b0;
                    if (req_valid) begin
                        case (cls)
                            CLS_CTRL: begin
                                reg_stb_q   <= 1'b1;
                                reg_q       <= req_in;
                                rsp_valid_q <= 1'b1;
                                rsp_err_q   <= 1'b0;
                                from_reg_q  <= 1'b1;
                                state_q     <= ST_RSP;
                            end
                            CLS_IOWIN: begin
                                io_valid_q <= 1'b1;
                                io_addr_q  <= io_window_base;
                                io_size_q  <= req_in.size;
                                io_write_q <= req_in.write;
                                io_wdata_q <= req_in.write ? wdata_be : '0;
                                state_q    <= ST_IO;
                            end
                            default: begin
                                rsp_valid_q <= 1'b1;
                                rsp_err_q   <= 1'b1;
                                rdata_q     <= '0;
                                from_reg_q  <= 1'b0;
                                state_q     <= ST_RSP;
                            end
                        endcase
                    end
                end
                ST_IO: begin
                    if (io_ack) begin
                        io_valid_q  <= 1'b0;
                        rsp_valid_q <= 1'b1;
                        rsp_err_q   <= io_err;
                        rdata_q     <= io_write_q ? '0 : rdata_be;
                        from_reg_q  <= 1'b0;
                        state_q     <= ST_RSP;
                    end
                end
                default: begin
                    rsp_valid_q <= 1'b0;
                    reg_stb_q   <= 1'b0;
                    state_q     <= ST_IDLE;
                end
            endcase
        end
    end

    assign rsp_valid    = rsp_valid_q;
    assign rsp_err      = rsp_valid_q & rsp_err_q;
    assign rsp_rdata    = !rsp_valid_q ? '0 : (from_reg_q ? reg_rdata : rdata_q);
    assign reg_stb      = reg_stb_q;
    assign reg_off      = reg_q.off;
    assign reg_size     = reg_q.size;
    assign reg_write    = reg_q.write;
    assign reg_wdata    = reg_q.wdata;
    assign io_req_valid = io_valid_q;
    assign io_req_addr  = io_addr_q;
    assign io_req_size  = io_size_q;
    assign io_req_write = io_write_q;
    assign io_req_wdata = io_wdata_q;

endmodule

// File: rtl/sized_port_validator_chk.sv
module sized_port_validator_chk #(
    parameter int IO_AW = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_size,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [31:0]      rsp_rdata,
    input logic             reg_stb,
    input logic             io_req_valid,
    input logic [IO_AW-1:0] io_req_addr,
    input logic [1:0]       io_req_size,
    input logic [31:0]      io_req_wdata,
    input logic             io_ack,
    input logic             io_err
);
    assert_bad_size_reject_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_size == 2'd3)
            |=> (rsp_valid && rsp_err && rsp_rdata == 32'd0 && !reg_stb && !io_req_valid));

    assert_io_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (io_req_valid && !io_ack)
            |=> (io_req_valid && $stable(io_req_addr) && $stable(io_req_size)
                 && $stable(io_req_wdata)));

    assert_io_err_pass_R9: assert property (@(posedge clk) disable iff (rst)
        (io_req_valid && io_ack) |=> (rsp_valid && rsp_err == $past(io_err)));

    assert_reg_ok_resp_R1: assert property (@(posedge clk) disable iff (rst)
        reg_stb |-> (rsp_valid && !rsp_err));

    assert_single_target_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_stb, io_req_valid}));

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || io_req_valid) |-> !req_ready);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind sized_port_validator sized_port_validator_chk #(.IO_AW(IO_AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_size     (req_size),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .reg_stb      (reg_stb),
    .io_req_valid (io_req_valid),
    .io_req_addr  (io_req_addr),
    .io_req_size  (io_req_size),
    .io_req_wdata (io_req_wdata),
    .io_ack       (io_ack),
    .io_err       (io_err)
);

// File: tb/sized_port_validator_tb_top.sv
`timescale 1ns/1ps
module sized_port_validator_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [15:0] io_window_base = 16'h03F8;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        reg_stb;
    logic [11:0] reg_off;
    logic [1:0]  reg_size;
    logic        reg_write;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        io_req_valid;
    logic [15:0] io_req_addr;
    logic [1:0]  io_req_size;
    logic        io_req_write;
    logic [31:0] io_req_wdata;
    logic        io_ack = 1'b0;
    logic [31:0] io_rdata = '0;
    logic        io_err = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sized_port_validator dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_off(req_off), .req_size(req_size), .req_write(req_write),
        .req_wdata(req_wdata), .io_window_base(io_window_base),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .reg_stb(reg_stb), .reg_off(reg_off), .reg_size(reg_size),
        .reg_write(reg_write), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .io_req_valid(io_req_valid), .io_req_addr(io_req_addr),
        .io_req_size(io_req_size), .io_req_write(io_req_write),
        .io_req_wdata(io_req_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
        .io_err(io_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] be_order(input logic [31:0] v, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[i*8 +: 8] = v[(n-1-i)*8 +: 8];
        return r;
    endfunction

    function automatic bit win_legal(input int lane, input int sz);
        if (sz == 3) return 0;
        if (lane == 0) return 1;
        if (lane == 2) return sz <= 1;
        return sz == 0;
    endfunction

    // Drive one request; returns at the falling edge of the cycle after acceptance.
    task automatic issue(input logic [11:0] off, input logic [1:0] sz, input bit wr,
                         input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_off = off; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_reject(input string req);
        check(rsp_valid && rsp_err, req, {30'd0, rsp_valid, rsp_err}, 32'h3);
        check(rsp_rdata == 32'd0, req, rsp_rdata, 32'd0);
        check(!reg_stb && !io_req_valid, req, {30'd0, reg_stb, io_req_valid}, 32'd0);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R10", {30'd0, rsp_valid, req_ready}, 32'h1);
    endtask

    // After issue() of a window access: serve it and check the response.
    task automatic serve_io(input string req, input logic [1:0] sz, input bit wr,
                            input logic [31:0] exp_wd, input logic [31:0] rd,
                            input bit err, input logic [31:0] exp_rd);
        check(io_req_valid, req, {31'd0, io_req_valid}, 32'd1);
        check(io_req_addr == io_window_base, "R7", {16'd0, io_req_addr}, {16'd0, io_window_base});
        check(io_req_size == sz && io_req_write == wr, "R7",
              {29'd0, io_req_write, io_req_size}, {29'd0, wr, sz});
        if (wr) check(io_req_wdata == exp_wd, "R8", io_req_wdata, exp_wd);
        check(!req_ready && !rsp_valid, "R10", {30'd0, req_ready, rsp_valid}, 32'd0);
        @(negedge clk);
        check(io_req_valid && io_req_addr == io_window_base, "R7",
              {15'd0, io_req_valid, io_req_addr}, {15'd0, 1'b1, io_window_base});
        io_ack = 1'b1; io_rdata = rd; io_err = err;
        @(negedge clk);
        io_ack = 1'b0; io_err = 1'b0;
        check(rsp_valid && rsp_err == err, "R9", {30'd0, rsp_valid, rsp_err}, {30'd0, 1'b1, err});
        check(rsp_rdata == exp_rd, "R9", rsp_rdata, exp_rd);
        check(!io_req_valid, "R7", {31'd0, io_req_valid}, 32'd0);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R10", {30'd0, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic t_reset();
        check(req_ready && !rsp_valid && !reg_stb && !io_req_valid, "R11",
              {28'd0, req_ready, rsp_valid, reg_stb, io_req_valid}, 32'h8);
    endtask

    task automatic t_ctrl();
        logic [11:0] offs [10] = '{12'h004, 12'h00C, 12'h010, 12'h014, 12'h018,
                                   12'h01C, 12'h024, 12'h028, 12'h038, 12'h060};
        for (int k = 0; k < 10; k++) begin
            logic [1:0]  sz = 2'(k % 3);
            logic [31:0] wd = 32'hA5000000 | 32'(k);
            reg_rdata = 32'hC0DE0000 | {20'd0, offs[k]};
            issue(offs[k], sz, k[0], wd);
            check(reg_stb && reg_off == offs[k] && reg_size == sz && reg_write == k[0],
                  "R1", {reg_stb, 17'd0, reg_size, reg_off}, {1'b1, 17'd0, sz, offs[k]});
            check(reg_wdata == wd, "R1", reg_wdata, wd);
            check(rsp_valid && !rsp_err && rsp_rdata == reg_rdata, "R1", rsp_rdata, reg_rdata);
            check(!req_ready, "R10", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            check(!reg_stb && !rsp_valid && req_ready, "R10",
                  {29'd0, reg_stb, rsp_valid, req_ready}, 32'h1);
        end
    endtask

    task automatic t_reject();
        logic [11:0] offs [9] = '{12'h000, 12'h008, 12'h020, 12'h030, 12'h064,
                                  12'h068, 12'h070, 12'h005, 12'hFFC};
        reg_rdata = 32'hFFFFFFFF;
        for (int k = 0; k < 9; k++) begin
            issue(offs[k], 2'd2, k[0], 32'h12345678);
            expect_reject("R2");
        end
    endtask

    task automatic t_bad_size();
        issue(12'h004, 2'd3, 1'b0, 32'd0);
        expect_reject("R6");
        issue(12'h06C, 2'd3, 1'b1, 32'd0);
        expect_reject("R6");
    endtask

    task automatic t_window_lanes();
        for (int lane = 0; lane < 4; lane++) begin
            for (int sz = 0; sz < 3; sz++) begin
                string tag = (lane == 0) ? "R3" : (lane == 2) ? "R4" : "R5";
                issue(12'h06C + 12'(lane), 2'(sz), 1'b0, 32'd0);
                if (win_legal(lane, sz))
                    serve_io(tag, 2'(sz), 1'b0, 32'd0, 32'h11223344, 1'b0,
                             be_order(32'h11223344, (sz == 0) ? 1 : (sz == 1) ? 2 : 4));
                else
                    expect_reject(tag);
            end
        end
    endtask

    task automatic t_byte_order();
        io_window_base = 16'h0CF8;
        issue(12'h06C, 2'd2, 1'b1, 32'h11223344);
        serve_io("R8", 2'd2, 1'b1, 32'h44332211, 32'hDEADBEEF, 1'b0, 32'd0);
        issue(12'h06E, 2'd1, 1'b1, 32'hFFFF1234);
        serve_io("R8", 2'd1, 1'b1, 32'h00003412, 32'd0, 1'b0, 32'd0);
        issue(12'h06F, 2'd0, 1'b1, 32'hFFFFFFAB);
        serve_io("R8", 2'd0, 1'b1, 32'h000000AB, 32'd0, 1'b0, 32'd0);
        issue(12'h06C, 2'd1, 1'b0, 32'd0);
        serve_io("R9", 2'd1, 1'b0, 32'd0, 32'hFFFFBEEF, 1'b0, 32'h0000EFBE);
        issue(12'h06D, 2'd0, 1'b0, 32'd0);
        serve_io("R9", 2'd0, 1'b0, 32'd0, 32'h12345699, 1'b1, 32'h00000099);
        issue(12'h06C, 2'd2, 1'b1, 32'h01020304);
        serve_io("R9", 2'd2, 1'b1, 32'h04030201, 32'd0, 1'b1, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_reject();
        t_bad_size();
        t_window_lanes();
        t_byte_order();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule